// File: doc/BRIEF.md
# Fragment Batch Overlap Detector

This block sits in front of one memory controller and groups a stream of pixel fragments into batches of at most eight. Downstream logic reads the stored depth data for a whole batch, runs its tests, and then writes back the visible results. The bus therefore turns around once per batch and not once per fragment. For this to be safe, no two fragments in the same batch may touch the same memory location. If they did, the second fragment would compare against a stale value.

The block keeps a small fully associative store holding a tag for each fragment in the current batch. A tag is only the bank bits and the column bits of the fragment's address. Row bits are not stored, so two fragments at the same column in different rows of one bank are treated as a conflict. The current batch ends when an arriving fragment hits a stored tag, or when the store already holds eight entries. The block then empties the store at once, writes the arriving fragment into it as the only entry, and sends that fragment downstream with a start-of-batch flag. Before it reads data for a flagged fragment, downstream must finish every write of the previous batch. Both sides use valid/ready handshakes. Fragments are never dropped or reordered, and the input stalls while the output register is full and not taken.

Top module: `frag_batch_detector`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1. The first fragment accepted after reset leaves with `outNewBatch` = 1.
- R2: A fragment whose bank and column equal those of a fragment already in the current batch leaves with `outNewBatch` = 1.
- R3: Row bits take no part in matching. A fragment with the same bank and column as a stored one but a different row leaves with `outNewBatch` = 1.
- R4: A fragment with the same column as a stored fragment but a different bank is not a conflict. It leaves with `outNewBatch` = 0 while the batch holds fewer than eight fragments.
- R5: The ninth fragment of a batch always leaves with `outNewBatch` = 1, even when its tag matches nothing stored.
- R6: When a batch ends, every stored tag is discarded and the triggering fragment becomes the only entry. A later fragment that matches only a tag from the old batch leaves with `outNewBatch` = 0. A repeat of the triggering fragment leaves with `outNewBatch` = 1.
- R7: Bank, row, column and payload pass through unchanged, one output per accepted input, in arrival order. Each one appears on the output one clock after it is accepted.
- R8: While `outValid` = 1 and `outReady` = 0, `inReady` is 0 and every output holds its value.
- R9: Within the output stream, every run that starts at a flagged fragment has at most eight fragments, and no two fragments in the run share a bank and column pair.
- R10: A fragment that arrives with the store full and that also matches a stored tag starts exactly one new batch. That batch then holds only this fragment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming fragment present |
| inReady | output | 1 | Block can take a fragment this cycle |
| inBank | input | BANK_W | Bank bits of the fragment address |
| inRow | input | ROW_W | Row bits of the fragment address |
| inCol | input | COL_W | Column bits of the fragment address |
| inData | input | DATA_W | Fragment payload carried alongside |
| outValid | output | 1 | Outgoing fragment present |
| outReady | input | 1 | Downstream takes the fragment this cycle |
| outBank | output | BANK_W | Bank bits of the outgoing fragment |
| outRow | output | ROW_W | Row bits of the outgoing fragment |
| outCol | output | COL_W | Column bits of the outgoing fragment |
| outData | output | DATA_W | Payload of the outgoing fragment |
| outNewBatch | output | 1 | Outgoing fragment opens a new batch |

## Verification
The two terminating conditions, a full store and a tag hit, can occur on the same arriving fragment. The bench provokes this by filling a batch with eight distinct tags and then resending one of them. It checks that this fragment is flagged once. It then checks that the store holds only that fragment: a tag from the discarded batch passes unflagged, and a repeat of the trigger is flagged. An output-stream monitor separately confirms that no batch exceeds eight fragments and that no batch repeats a bank and column pair.

// File: rtl/frag_batch_pkg.sv
package frag_batch_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;    // fragment taken this cycle
    logic startNew;  // it opens a new batch
  } batch_strobe_t;
endpackage

// File: rtl/fbd_control.sv
module fbd_control
  import frag_batch_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             outReady,
  input  logic             tagHit,
  output logic             inReady,
  output logic             outValid,
  output batch_strobe_t    strobe,
  output logic [CNT_W-1:0] fillCount
);
  logic storeFull;
  logic storeEmpty;

  assign storeFull  = (fillCount == CNT_W'(DEPTH));
  assign storeEmpty = (fillCount == '0);
  assign inReady    = !outValid || outReady;

  always_comb begin
    strobe.accept   = inValid && inReady;
    strobe.startNew = strobe.accept && (storeEmpty || storeFull || tagHit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fillCount <= '0;
      outValid  <= 1'b0;
    end else begin
      if (strobe.startNew)    fillCount <= CNT_W'(1);
      else if (strobe.accept) fillCount <= fillCount + CNT_W'(1);
      if (strobe.accept)      outValid <= 1'b1;
      else if (outReady)      outValid <= 1'b0;
    end
  end

  // R5
  full_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && storeFull) |=> (fillCount == CNT_W'(1)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |-> !inReady);

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> outValid);

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fillCount <= CNT_W'(DEPTH));
endmodule

// File: rtl/fbd_datapath.sv
module fbd_datapath
  import frag_batch_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int COL_W  = 6,
  parameter int ROW_W  = 8,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TAG_W = BANK_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  batch_strobe_t     strobe,
  input  logic [CNT_W-1:0]  fillCount,
  input  logic              outValid,
  input  logic              outReady,
  input  logic [BANK_W-1:0] inBank,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  input  logic [DATA_W-1:0] inData,
  output logic              tagHit,
  output logic [BANK_W-1:0] outBank,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic [DATA_W-1:0] outData,
  output logic              outNewBatch
);
  logic [TAG_W-1:0] tagMem [DEPTH];
  logic [DEPTH-1:0] entValid;
  logic [DEPTH-1:0] entHit;
  logic [TAG_W-1:0] inTag;

  assign inTag  = {inBank, inCol};
  assign tagHit = |entHit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wrEn;
    assign entHit[i] = entValid[i] && (tagMem[i] == inTag);
    assign wrEn = strobe.accept &&
                  (strobe.startNew ? (i == 0) : (fillCount == CNT_W'(i)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entValid[i] <= 1'b0;
        tagMem[i]   <= '0;
      end else if (wrEn) begin
        entValid[i] <= 1'b1;
        tagMem[i]   <= inTag;
      end else if (strobe.startNew) begin
        entValid[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outBank     <= '0;
      outRow      <= '0;
      outCol      <= '0;
      outData     <= '0;
      outNewBatch <= 1'b0;
    end else if (strobe.accept) begin
      outBank     <= inBank;
      outRow      <= inRow;
      outCol      <= inCol;
      outData     <= inData;
      outNewBatch <= strobe.startNew;
    end
  end

  // R2
  hit_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.accept && tagHit) |=> outNewBatch);

  // R6
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.startNew |=> (entValid == DEPTH'(1)));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> ($stable(outData) && $stable(outBank) &&
      $stable(outCol) && $stable(outRow) && $stable(outNewBatch)));
endmodule

// File: rtl/frag_batch_detector.sv
module frag_batch_detector
  import frag_batch_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int COL_W  = 6,
  parameter int ROW_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BANK_W-1:0] inBank,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [BANK_W-1:0] outBank,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol,
  output logic [DATA_W-1:0] outData,
  output logic              outNewBatch
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  batch_strobe_t    strobe;
  logic [CNT_W-1:0] fillCount;
  logic             tagHit;

  fbd_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outReady(outReady),
    .tagHit(tagHit), .inReady(inReady), .outValid(outValid),
    .strobe(strobe), .fillCount(fillCount)
  );

  fbd_datapath #(
    .DEPTH(DEPTH), .BANK_W(BANK_W), .COL_W(COL_W),
    .ROW_W(ROW_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fillCount(fillCount),
    .outValid(outValid), .outReady(outReady),
    .inBank(inBank), .inRow(inRow), .inCol(inCol), .inData(inData),
    .tagHit(tagHit), .outBank(outBank), .outRow(outRow), .outCol(outCol),
    .outData(outData), .outNewBatch(outNewBatch)
  );

  // R1
  first_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && fillCount == '0) |=> outNewBatch);
endmodule

// File: tb/frag_batch_detector_test.sv
`timescale 1ns/1ps
module frag_batch_detector_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        inValid = 0;
  logic        inReady;
  logic [1:0]  inBank = 0;
  logic [7:0]  inRow = 0;
  logic [5:0]  inCol = 0;
  logic [15:0] inData = 0;
  logic        outValid;
  logic        outReady = 1;
  logic [1:0]  outBank;
  logic [7:0]  outRow;
  logic [5:0]  outCol;
  logic [15:0] outData;
  logic        outNewBatch;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  frag_batch_detector uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inBank(inBank), .inRow(inRow), .inCol(inCol), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outBank(outBank),
    .outRow(outRow), .outCol(outCol), .outData(outData),
    .outNewBatch(outNewBatch)
  );

  always #2.5 clk = ~clk;

  // vector: {bank, col, row, expected mark}
  localparam logic [16:0] VEC [14] = '{
    {2'd0, 6'd1, 8'd0, 1'b1},  // R1 first after reset
    {2'd0, 6'd2, 8'd0, 1'b0},
    {2'd1, 6'd1, 8'd0, 1'b0},  // R4 other bank
    {2'd0, 6'd1, 8'd5, 1'b1},  // R3 other row same bank/col
    {2'd0, 6'd2, 8'd0, 1'b0},  // R6 old tag forgotten
    {2'd0, 6'd3, 8'd1, 1'b0},
    {2'd0, 6'd4, 8'd1, 1'b0},
    {2'd0, 6'd5, 8'd1, 1'b0},
    {2'd0, 6'd6, 8'd1, 1'b0},
    {2'd0, 6'd7, 8'd1, 1'b0},
    {2'd0, 6'd8, 8'd1, 1'b0},  // eighth entry
    {2'd2, 6'd9, 8'd2, 1'b1},  // R5 ninth
    {2'd2, 6'd9, 8'd3, 1'b1},  // R2 hit on fresh entry
    {2'd3, 6'd9, 8'd3, 1'b0}   // R4
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 0; inValid = 0; outReady = 1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  // drive one fragment, check it one cycle later (output ready)
  task automatic sendCheck(input logic [1:0] b, input logic [5:0] c,
                           input logic [7:0] r, input logic [15:0] d,
                           input bit mark, input string req);
    @(negedge clk);
    inBank = b; inCol = c; inRow = r; inData = d; inValid = 1;
    @(negedge clk);
    inValid = 0;
    chk(outValid == 1, "R7", outValid, 1);
    chk(outData == d && outBank == b && outCol == c && outRow == r, "R7",
        outData, d);
    chk(outNewBatch == mark, req, outNewBatch, mark);
  endtask

  // R9 downstream model: a batch must be free of reduced-tag repeats
  logic [7:0] seenTag [8];
  int seenCnt = 0;
  int batchViol = 0;
  always @(posedge clk) begin
    if (rst_n && outValid && outReady) begin
      if (outNewBatch) begin
        seenCnt = 1;
        seenTag[0] = {outBank, outCol};
      end else begin
        if (seenCnt >= 8) batchViol++;
        for (int k = 0; k < 8; k++)
          if (k < seenCnt && seenTag[k] == {outBank, outCol}) batchViol++;
        if (seenCnt < 8) seenTag[seenCnt] = {outBank, outCol};
        seenCnt++;
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    chk(outValid == 0, "R1", outValid, 0);
    chk(inReady == 1, "R1", inReady, 1);

    for (int i = 0; i < 14; i++)
      sendCheck(VEC[i][16:15], VEC[i][14:9], VEC[i][8:1], 16'(i + 100),
                VEC[i][0], "R2/R3/R4/R5");

    // R10: full store and hit together
    doReset();
    for (int i = 0; i < 8; i++)
      sendCheck(2'd1, 6'(i), 8'd0, 16'(i), (i == 0), "R10");
    sendCheck(2'd1, 6'd3, 8'd9, 16'h33, 1'b1, "R10");
    sendCheck(2'd1, 6'd5, 8'd0, 16'h35, 1'b0, "R6");
    sendCheck(2'd1, 6'd3, 8'd0, 16'h36, 1'b1, "R6");

    // R8 backpressure
    doReset();
    outReady = 0;
    @(negedge clk);
    inBank = 2'd2; inCol = 6'd10; inRow = 8'd1; inData = 16'hAAAA; inValid = 1;
    @(negedge clk);
    inBank = 2'd2; inCol = 6'd11; inRow = 8'd1; inData = 16'hBBBB;
    chk(outValid == 1 && outData == 16'hAAAA, "R8", outData, 16'hAAAA);
    chk(inReady == 0, "R8", inReady, 0);
    @(negedge clk);
    chk(outData == 16'hAAAA && outNewBatch == 1, "R8", outData, 16'hAAAA);
    chk(inReady == 0, "R8", inReady, 0);
    outReady = 1;
    @(negedge clk);
    inValid = 0;
    chk(outValid == 1 && outData == 16'hBBBB, "R7", outData, 16'hBBBB);
    chk(outNewBatch == 0, "R4", outNewBatch, 0);
    @(negedge clk);
    chk(outValid == 0, "R7", outValid, 0);

    // R9 stream-level batch rule
    chk(batchViol == 0, "R9", batchViol, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule